// File: doc/BRIEF.md
# Host/Controller Command Mailbox

A register-mapped mailbox that joins a host register bus to an embedded controller. The host fills a command word, whose low byte is the opcode, and three 32-bit argument words. It then rings a doorbell by writing 1 to bit 0 of the control word. The same doorbell bit tells both sides who owns the outbound registers. While the bit is set, the controller sees a level-valid command with its opcode and arguments. When the controller pulses its completion input, the bit clears, and this tells the host it may post again.

The return path works the other way. The controller posts a reply made of a 10-bit echoed command, a 6-bit payload length and three data words. The block packs the command and length into one header word and raises a reply doorbell. The host reads the reply and then frees the slot by writing 0 to the reply doorbell. The block decodes the usual acknowledge codes from the first reply data word.

Two guards are host-visible. A sticky overrun bit records any attempt to change the outbound registers while the doorbell is set. A timeout flag rises once the doorbell has stayed set for a programmable number of cycles.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset every register reads 0, except the timeout limit at word address 5, which reads the `TMO_RST` parameter. `ctl_cmd_valid` and `rpl_busy` are low.
- R2: Word address map: 0 is the command, 1 to 3 are arguments 1 to 3, 4 is control, 5 is the timeout limit, 6 is the reply header, 7 to 9 are reply words 1 to 3, and 10 is reply control. Other addresses read 0. While the doorbell is clear, host writes to addresses 0 to 3 are stored and read back. `ctl_opcode` equals command bits 7:0. `ctl_data` carries argument k at bits [(k-1)*32 +: 32].
- R3: Writing control with bit 0 = 1 while the doorbell is clear sets the doorbell on that clock edge. `ctl_cmd_valid` and control bit 0 then read 1.
- R4: A one-cycle `ctl_done` while the doorbell is set clears it at the next edge. `ctl_done` while the doorbell is clear changes nothing.
- R5: While the doorbell is set, writes to addresses 0 to 3, and control writes with bit 0 = 1, are dropped. Each such write sets the sticky overrun flag, control bit 1. A control write with bit 1 = 1 clears the flag, unless the same write is itself an overrun.
- R6: Control bit 2 (timeout) reads 1 once the doorbell has been set for at least LIMIT clock edges after the posting edge. It reads 0 whenever the doorbell is clear. A LIMIT of 0 disables the timeout.
- R7: A `rpl_post` pulse while the reply doorbell is clear stores header = {zeros, len[5:0] at bits 15:10, cmd[9:0] at bits 9:0} and reply words 1 to 3 from `rpl_data` (same packing as `ctl_data`). It also sets the reply doorbell, which is reply-control bit 0 and `rpl_busy`.
- R8: A `rpl_post` while the reply doorbell is set is ignored and the stored reply does not change.
- R9: A host write to reply control with bit 0 = 0 clears the reply doorbell. Host writes to addresses 6 to 9 have no effect.
- R10: Reply-control bit 1 reads 1 when reply word 1 equals 1 (ACK). Bit 2 reads 1 when reply word 1 equals 2 (NACK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | 4 | Host word address |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Host read data, combinational from address |
| ctl_cmd_valid | output | 1 | Doorbell level: a command is pending |
| ctl_opcode | output | 8 | Command opcode (command bits 7:0) |
| ctl_data | output | 3*DATA_W | Arguments 1..3, argument 1 in the low word |
| ctl_done | input | 1 | Controller completion pulse |
| rpl_post | input | 1 | Controller reply post pulse |
| rpl_cmd | input | 10 | Echoed command for the reply header |
| rpl_len | input | 6 | Payload length for the reply header |
| rpl_data | input | 3*DATA_W | Reply words 1..3, word 1 in the low word |
| rpl_busy | output | 1 | Reply doorbell level |

## Verification
The bench posts every one of the 256 opcodes and checks the controller view and the doorbell for each. A design that decodes the opcode from the wrong byte, or that fails to release the doorbell on completion, fails this sweep. Writes made while the doorbell is set must leave the stored command untouched and must set the overrun flag. A design that lets such a write through corrupts a command the controller is still reading.

The timeout is swept over several limits, and the bench checks the exact edge where the flag rises. This catches an off-by-one count or a counter that is not restarted between posts. The reply path is driven with 64 command and length pairs. These expose a misplaced header field, a second post that overwrites an unread reply, a host that can corrupt reply words, and ACK/NACK decodes that are swapped.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int AW         = 4;
  localparam int NDATA      = 3;
  localparam int OPC_W      = 8;
  localparam int RHDR_CMD_W = 10;
  localparam int RHDR_LEN_W = 6;

  localparam logic [AW-1:0] ADR_CMD   = 4'd0;
  localparam logic [AW-1:0] ADR_DAT0  = 4'd1;
  localparam logic [AW-1:0] ADR_CTL   = 4'd4;
  localparam logic [AW-1:0] ADR_LIM   = 4'd5;
  localparam logic [AW-1:0] ADR_RCMD  = 4'd6;
  localparam logic [AW-1:0] ADR_RDAT0 = 4'd7;
  localparam logic [AW-1:0] ADR_RCTL  = 4'd10;

  localparam int ACK_CODE  = 1;
  localparam int NACK_CODE = 2;
endpackage

// File: rtl/mbx_fwd.sv
module mbx_fwd
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    done,
  output logic                    db_o,
  output logic                    ovr_o,
  output logic [DATA_W-1:0]       cmd_o,
  output logic [NDATA*DATA_W-1:0] data_o
);
  logic              db_q, db_d;
  logic              ovr_q, ovr_d;
  logic [DATA_W-1:0] cmd_q, cmd_d;
  logic [NDATA-1:0]  dat_sel;
  logic              cmd_sel, ctl_sel, post_req, busy_wr;

  assign cmd_sel  = we && (addr == ADR_CMD);
  assign ctl_sel  = we && (addr == ADR_CTL);
  assign post_req = ctl_sel && wdata[0];
  assign busy_wr  = db_q && (cmd_sel || (|dat_sel) || post_req);

  for (genvar g = 0; g < NDATA; g++) begin : g_dat
    localparam logic [AW-1:0] MYADR = ADR_DAT0 + AW'(g);
    logic [DATA_W-1:0] q, d;
    assign dat_sel[g] = we && (addr == MYADR);
    always_comb d = (dat_sel[g] && !db_q) ? wdata : q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q <= '0;
      else        q <= d;
    assign data_o[g*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    cmd_d = (cmd_sel && !db_q) ? wdata : cmd_q;
    db_d  = db_q;
    if (db_q && done)          db_d = 1'b0;
    else if (!db_q && post_req) db_d = 1'b1;
    ovr_d = ovr_q;
    if (busy_wr)                    ovr_d = 1'b1;
    else if (ctl_sel && wdata[1])   ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q  <= 1'b0;
      ovr_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      db_q  <= db_d;
      ovr_q <= ovr_d;
      cmd_q <= cmd_d;
    end
  end

  assign db_o  = db_q;
  assign ovr_o = ovr_q;
  assign cmd_o = cmd_q;

  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (db_q && done) |=> !db_q);
  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (db_q && !done) |=> ($stable(cmd_q) && $stable(data_o)));
  assert_post_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!db_q && post_req) |=> db_q);
endmodule

// File: rtl/mbx_timer.sv
module mbx_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [CNT_W-1:0] limit,
  output logic             tmo
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!busy)        cnt_d = '0;
    else if (&cnt_q)  cnt_d = cnt_q;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign tmo = busy && (limit != '0) && (cnt_q >= limit);

  assert_count_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt_q == '0));
endmodule

// File: rtl/mbx_rev.sv
module mbx_rev
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    post,
  input  logic [RHDR_CMD_W-1:0]   rcmd,
  input  logic [RHDR_LEN_W-1:0]   rlen,
  input  logic [NDATA*DATA_W-1:0] rdata,
  input  logic                    host_clr,
  output logic                    rdb_o,
  output logic [DATA_W-1:0]       hdr_o,
  output logic [NDATA*DATA_W-1:0] data_o
);
  localparam int PAD_W = DATA_W - RHDR_CMD_W - RHDR_LEN_W;

  logic              rdb_q, rdb_d;
  logic [DATA_W-1:0] hdr_q, hdr_d;
  logic              accept;

  assign accept = post && !rdb_q;

  for (genvar g = 0; g < NDATA; g++) begin : g_rdat
    logic [DATA_W-1:0] q, d;
    always_comb d = accept ? rdata[g*DATA_W +: DATA_W] : q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q <= '0;
      else        q <= d;
    assign data_o[g*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    hdr_d = accept ? {{PAD_W{1'b0}}, rlen, rcmd} : hdr_q;
    rdb_d = rdb_q;
    if (accept)        rdb_d = 1'b1;
    else if (host_clr) rdb_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdb_q <= 1'b0;
      hdr_q <= '0;
    end else begin
      rdb_q <= rdb_d;
      hdr_q <= hdr_d;
    end
  end

  assign rdb_o = rdb_q;
  assign hdr_o = hdr_q;

  assert_post_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (post && !rdb_q) |=> rdb_q);
  assert_reject_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdb_q && post) |=> ($stable(hdr_q) && $stable(data_o)));
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TMO_W   = 16,
  parameter int TMO_RST = 1000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hst_we,
  input  logic [AW-1:0]             hst_addr,
  input  logic [DATA_W-1:0]         hst_wdata,
  output logic [DATA_W-1:0]         hst_rdata,
  output logic                      ctl_cmd_valid,
  output logic [OPC_W-1:0]          ctl_opcode,
  output logic [NDATA*DATA_W-1:0]   ctl_data,
  input  logic                      ctl_done,
  input  logic                      rpl_post,
  input  logic [RHDR_CMD_W-1:0]     rpl_cmd,
  input  logic [RHDR_LEN_W-1:0]     rpl_len,
  input  logic [NDATA*DATA_W-1:0]   rpl_data,
  output logic                      rpl_busy
);
  logic                    db, ovr, tmo, rdb, ack, nack, rclr;
  logic [DATA_W-1:0]       cmd_w, rhdr;
  logic [NDATA*DATA_W-1:0] rwords;
  logic [TMO_W-1:0]        lim_q, lim_d;

  mbx_fwd #(.DATA_W(DATA_W)) u_fwd (
    .clk(clk), .rst_n(rst_n), .we(hst_we), .addr(hst_addr), .wdata(hst_wdata),
    .done(ctl_done), .db_o(db), .ovr_o(ovr), .cmd_o(cmd_w), .data_o(ctl_data)
  );

  mbx_timer #(.CNT_W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .busy(db), .limit(lim_q), .tmo(tmo)
  );

  assign rclr = hst_we && (hst_addr == ADR_RCTL) && !hst_wdata[0];

  mbx_rev #(.DATA_W(DATA_W)) u_rev (
    .clk(clk), .rst_n(rst_n), .post(rpl_post), .rcmd(rpl_cmd), .rlen(rpl_len),
    .rdata(rpl_data), .host_clr(rclr), .rdb_o(rdb), .hdr_o(rhdr), .data_o(rwords)
  );

  always_comb lim_d = (hst_we && (hst_addr == ADR_LIM)) ? hst_wdata[TMO_W-1:0] : lim_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lim_q <= TMO_W'(TMO_RST);
    else        lim_q <= lim_d;

  assign ack  = (rwords[DATA_W-1:0] == DATA_W'(ACK_CODE));
  assign nack = (rwords[DATA_W-1:0] == DATA_W'(NACK_CODE));

  always_comb begin
    hst_rdata = '0;
    case (hst_addr)
      ADR_CMD:        hst_rdata = cmd_w;
      4'd1:           hst_rdata = ctl_data[0*DATA_W +: DATA_W];
      4'd2:           hst_rdata = ctl_data[1*DATA_W +: DATA_W];
      4'd3:           hst_rdata = ctl_data[2*DATA_W +: DATA_W];
      ADR_CTL:        hst_rdata = DATA_W'({tmo, ovr, db});
      ADR_LIM:        hst_rdata = DATA_W'(lim_q);
      ADR_RCMD:       hst_rdata = rhdr;
      4'd7:           hst_rdata = rwords[0*DATA_W +: DATA_W];
      4'd8:           hst_rdata = rwords[1*DATA_W +: DATA_W];
      4'd9:           hst_rdata = rwords[2*DATA_W +: DATA_W];
      ADR_RCTL:       hst_rdata = DATA_W'({nack, ack, rdb});
      default:        hst_rdata = '0;
    endcase
  end

  assign ctl_cmd_valid = db;
  assign ctl_opcode    = cmd_w[OPC_W-1:0];
  assign rpl_busy      = rdb;

  assert_tmo_needs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> ctl_cmd_valid);
  assert_ack_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && nack));
endmodule

// File: tb/tb_mbx_mailbox.sv
`timescale 1ns/1ps
module tb_mbx_mailbox;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hst_we;
  logic [3:0]    hst_addr;
  logic [DW-1:0] hst_wdata, hst_rdata;
  logic          ctl_cmd_valid, ctl_done, rpl_post, rpl_busy;
  logic [7:0]    ctl_opcode;
  logic [3*DW-1:0] ctl_data, rpl_data;
  logic [9:0]    rpl_cmd;
  logic [5:0]    rpl_len;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  mbx_mailbox dut (
    .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .ctl_cmd_valid(ctl_cmd_valid),
    .ctl_opcode(ctl_opcode), .ctl_data(ctl_data), .ctl_done(ctl_done),
    .rpl_post(rpl_post), .rpl_cmd(rpl_cmd), .rpl_len(rpl_len),
    .rpl_data(rpl_data), .rpl_busy(rpl_busy)
  );

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic hwr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(posedge clk);
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic hrd(input logic [3:0] a, output logic [DW-1:0] d);
    hst_addr = a;
    #1;
    d = hst_rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    ctl_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ctl_done = 1'b0;
  endtask

  task automatic rpost(input logic [9:0] c, input logic [5:0] l, input logic [3*DW-1:0] d);
    @(negedge clk);
    rpl_post = 1'b1; rpl_cmd = c; rpl_len = l; rpl_data = d;
    @(posedge clk);
    @(negedge clk);
    rpl_post = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    rst_n = 1'b0; hst_we = 1'b0; hst_addr = '0; hst_wdata = '0;
    ctl_done = 1'b0; rpl_post = 1'b0; rpl_cmd = '0; rpl_len = '0; rpl_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 16; a++) begin
      hrd(4'(a), r);
      chk($sformatf("R1 reset addr %0d", a), r, (a == 5) ? 32'd1000 : 32'd0);
    end
    chk("R1 cmd_valid", {31'b0, ctl_cmd_valid}, 0);
    chk("R1 rpl_busy", {31'b0, rpl_busy}, 0);

    // R2 R3 R4: every opcode posted, seen, completed
    for (int op = 0; op < 256; op++) begin
      logic [DW-1:0] cw;
      cw = {8'(op ^ 8'h5A), 8'(op + 3), 8'(~op), 8'(op)};
      hwr(4'd0, cw);
      for (int k = 0; k < 3; k++) hwr(4'(1 + k), cw + 32'(k * 32'h1111_0000));
      hrd(4'd0, r); chk("R2 cmd readback", r, cw);
      hrd(4'd2, r); chk("R2 arg2 readback", r, cw + 32'h1111_0000);
      hwr(4'd4, 32'h1);
      chk("R3 cmd_valid after post", {31'b0, ctl_cmd_valid}, 1);
      chk("R2 opcode", {24'b0, ctl_opcode}, 32'(op));
      chk("R2 ctl_data arg1", ctl_data[0 +: DW], cw);
      chk("R2 ctl_data arg3", ctl_data[2*DW +: DW], cw + 32'h2222_0000);
      hrd(4'd4, r); chk("R3 ctl reads posted", r, 32'h1);
      done_pulse();
      chk("R4 done clears", {31'b0, ctl_cmd_valid}, 0);
    end

    // R4: done while idle has no effect
    done_pulse();
    hrd(4'd4, r); chk("R4 idle done", r, 32'h0);
    chk("R4 idle done valid", {31'b0, ctl_cmd_valid}, 0);

    // R5: overrun
    hwr(4'd0, 32'hAAAA_0020);
    hwr(4'd1, 32'h1234_5678);
    hwr(4'd4, 32'h1);
    hwr(4'd0, 32'hBBBB_0021);
    hrd(4'd0, r); chk("R5 cmd write dropped", r, 32'hAAAA_0020);
    chk("R5 opcode kept", {24'b0, ctl_opcode}, 32'h20);
    hrd(4'd4, r); chk("R5 overrun set", r, 32'h3);
    hwr(4'd4, 32'h2);
    hrd(4'd4, r); chk("R5 overrun cleared", r, 32'h1);
    hwr(4'd1, 32'hDEAD_BEEF);
    hrd(4'd1, r); chk("R5 data write dropped", r, 32'h1234_5678);
    chk("R5 ctl_data kept", ctl_data[0 +: DW], 32'h1234_5678);
    hrd(4'd4, r); chk("R5 overrun from data", r, 32'h3);
    hwr(4'd4, 32'h3);
    hrd(4'd4, r); chk("R5 repost while busy keeps overrun", r, 32'h3);
    done_pulse();
    hwr(4'd4, 32'h2);
    hrd(4'd4, r); chk("R5 overrun cleared idle", r, 32'h0);

    // R6: timeout edge sweep
    for (int lim = 0; lim <= 6; lim++) begin
      hwr(4'd5, 32'(lim));
      hwr(4'd4, 32'h1);
      hrd(4'd4, r); chk($sformatf("R6 lim=%0d k=0", lim), {31'b0, r[2]}, 0);
      for (int k = 1; k <= 8; k++) begin
        @(posedge clk); @(negedge clk);
        hrd(4'd4, r);
        chk($sformatf("R6 lim=%0d k=%0d", lim, k), {31'b0, r[2]},
            32'((lim != 0) && (k >= lim)));
      end
      done_pulse();
      hrd(4'd4, r); chk($sformatf("R6 lim=%0d cleared", lim), r, 32'h0);
    end

    // R7 R8 R9 R10: reply sweep
    for (int i = 0; i < 64; i++) begin
      logic [9:0] c;
      logic [3*DW-1:0] d;
      logic [3*DW-1:0] d2;
      c = 10'((i * 97 + 5) & 1023);
      d = {32'(i) * 32'h0101_0101 + 32'd2, 32'(i) * 32'h0101_0101 + 32'd1, 32'(i % 4)};
      d2 = ~d;
      rpost(c, 6'(i), d);
      chk("R7 rpl_busy", {31'b0, rpl_busy}, 1);
      hrd(4'd6, r); chk("R7 header", r, {16'b0, 6'(i), c});
      hrd(4'd8, r); chk("R7 word2", r, 32'(i) * 32'h0101_0101 + 32'd1);
      hrd(4'd10, r);
      chk("R10 ack/nack decode", r, {29'b0, (i % 4) == 2, (i % 4) == 1, 1'b1});
      rpost(~c, ~6'(i), d2);
      hrd(4'd6, r); chk("R8 header kept", r, {16'b0, 6'(i), c});
      hrd(4'd7, r); chk("R8 word1 kept", r, 32'(i % 4));
      hwr(4'd9, 32'hFFFF_FFFF);
      hwr(4'd6, 32'hFFFF_FFFF);
      hrd(4'd9, r); chk("R9 host write word3 ignored", r, 32'(i) * 32'h0101_0101 + 32'd2);
      hrd(4'd6, r); chk("R9 host write header ignored", r, {16'b0, 6'(i), c});
      hwr(4'd10, 32'h0);
      chk("R9 reply doorbell cleared", {31'b0, rpl_busy}, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule